// File: doc/BRIEF.md
# Serial Master FIFO and Watermark Register Front End

This block is the bus-facing half of a serial peripheral master. It holds a 32-bit register file that software reads and writes through a simple single-cycle bus. Inside are two word queues of 8-bit entries: one feeds the serial shifting engine, and one collects what the engine receives. It also keeps the configuration values that the engine needs: clock divisor, clock mode, select index, select idle levels, select mode, delay pairs, frame format and the memory-mapped flash controls. Each of these is driven out on its own port.

Software loads outgoing words by writing the transmit data register. It collects incoming words by reading the receive data register. Bit 31 of either data register reports a full transmit queue or an empty receive queue. Two threshold registers set the level at which each queue raises a pending flag. An enable register selects which pending flags reach the single interrupt line. Software can find how many select lines exist by writing all ones to the select-default register and reading it back. The shifting engine connects through a pop port on the transmit queue and a push port on the receive queue.

Top module: `spi_wm_regs`

## Requirements
- R1: After reset, the enable register (0x70) reads 0, the transmit threshold (0x50) reads 1, the receive threshold (0x54) reads 0, flash control (0x60) reads 0, the pending register (0x74) reads 1 and `irq` is low.
- R2: A write to transmit data (0x48) queues bits 7:0. The engine side sees the queued words on `txPopData` in write order, one per `txPopReq` cycle, and `txHasData` is high while any word is queued.
- R3: A read of transmit data returns bit 31 set exactly when the transmit queue holds DEPTH words, with all other bits 0. A write while it is full is discarded.
- R4: A read of receive data (0x4C) from a non-empty queue returns the oldest word in bits 7:0 with bit 31 clear, and removes that word. `rxHasRoom` is low while the queue holds DEPTH words.
- R5: A read of receive data from an empty queue returns 0x8000_0000 and does not disturb the queue: a word pushed afterwards is the next one read.
- R6: Pending bit 0 (transmit) is 1 while the transmit word count is strictly less than the transmit threshold.
- R7: Pending bit 1 (receive) is 1 while the receive word count is strictly greater than the receive threshold, so a threshold of n-1 signals n words held.
- R8: `irq` is the OR over bits 1:0 of enable AND pending. Writes to the pending register are ignored.
- R9: Writing 0xFFFF_FFFF to select-default (0x14) reads back ones only in the low NUM_CS bit positions, and drives them on `csDefault`.
- R10: Offsets outside the map (for example 0x08 and 0x20) read as zero, and writes to them change no register.
- R11: Configuration registers keep only their defined fields. Clock divisor (0x00) keeps bits 11:0, clock mode (0x04) bits 1:0, select mode (0x18) bits 1:0, and frame format (0x40) bits 3:0 and 19:16. Each field appears on its output port.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low asynchronous reset |
| busSel | input | 1 | Bus access strobe, one cycle per access |
| busWrite | input | 1 | 1 = write, 0 = read |
| busAddr | input | ADDR_W | Byte offset |
| busWdata | input | 32 | Write data |
| busRdata | output | 32 | Read data, combinational while busSel is high and busWrite is low |
| irq | output | 1 | Interrupt request |
| txPopReq | input | 1 | Engine takes the head transmit word |
| txPopData | output | 8 | Head transmit word |
| txHasData | output | 1 | Transmit queue not empty |
| rxPushReq | input | 1 | Engine delivers a received word |
| rxPushData | input | 8 | Received word |
| rxHasRoom | output | 1 | Receive queue not full |
| sckDiv | output | 12 | Clock divisor |
| sckMode | output | 2 | Clock phase and polarity |
| csId | output | CS_W | Selected line index |
| csDefault | output | NUM_CS | Idle level of each select line |
| csMode | output | 2 | Select line mode |
| delay0 | output | 32 | Select-to-clock delays, fields 7:0 and 23:16 |
| delay1 | output | 32 | Inter-select and inter-frame delays, fields 7:0 and 23:16 |
| frameFmt | output | 32 | Frame format, fields 3:0 and 19:16 |
| flashCtrl | output | 1 | Memory-mapped flash enable |
| flashFmt | output | 32 | Flash command format |

## Verification
The hardest cases to reach are at the queue edges: a ninth transmit write into a full queue, and a receive read from an empty queue. Both must leave the pointers exactly where they were. The bench fills the transmit queue past DEPTH with distinct values and then drains it, so a dropped or overwritten word shows up as a wrong value or a wrong count. It reads the empty receive queue and then pushes one word, so a stray pointer move would return stale data. The threshold comparisons are probed one word on each side of the programmed mark.

// File: rtl/spi_wm_pkg.sv
package spi_wm_pkg;
  localparam int WORD_W = 8;

  localparam logic [7:0] OFF_SCKDIV  = 8'h00;
  localparam logic [7:0] OFF_SCKMODE = 8'h04;
  localparam logic [7:0] OFF_CSID    = 8'h10;
  localparam logic [7:0] OFF_CSDEF   = 8'h14;
  localparam logic [7:0] OFF_CSMODE  = 8'h18;
  localparam logic [7:0] OFF_DLY0    = 8'h28;
  localparam logic [7:0] OFF_DLY1    = 8'h2C;
  localparam logic [7:0] OFF_FMT     = 8'h40;
  localparam logic [7:0] OFF_TXDATA  = 8'h48;
  localparam logic [7:0] OFF_RXDATA  = 8'h4C;
  localparam logic [7:0] OFF_TXMARK  = 8'h50;
  localparam logic [7:0] OFF_RXMARK  = 8'h54;
  localparam logic [7:0] OFF_FCTRL   = 8'h60;
  localparam logic [7:0] OFF_FFMT    = 8'h64;
  localparam logic [7:0] OFF_IE      = 8'h70;
  localparam logic [7:0] OFF_IP      = 8'h74;

  localparam logic [31:0] DLY_MASK = 32'h00FF_00FF;
  localparam logic [31:0] FMT_MASK = 32'h000F_000F;

  // control -> datapath strobes
  typedef struct packed {
    logic              txPush;
    logic [WORD_W-1:0] txWord;
    logic              rxPop;
  } fifoStrobe_t;
endpackage

// File: rtl/spi_wm_fifo.sv
module spi_wm_fifo #(
  parameter int DEPTH = 8,
  parameter int WIDTH = 8,
  localparam int PTR_W = (DEPTH > 1) ? $clog2(DEPTH) : 1,
  localparam int CNT_W = $clog2(DEPTH + 1)
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             push,
  input  logic [WIDTH-1:0] pushData,
  input  logic             pop,
  output logic [WIDTH-1:0] popData,
  output logic [CNT_W-1:0] count,
  output logic             full,
  output logic             empty
);
  logic [WIDTH-1:0] mem [DEPTH];
  logic [PTR_W-1:0] wrPtr, rdPtr;
  logic doPush, doPop;

  assign full    = (count == CNT_W'(DEPTH));
  assign empty   = (count == '0);
  assign doPush  = push && !full;
  assign doPop   = pop && !empty;
  assign popData = mem[rdPtr];

  function automatic logic [PTR_W-1:0] nextPtr(input logic [PTR_W-1:0] p);
    return (p == PTR_W'(DEPTH - 1)) ? '0 : p + 1'b1;
  endfunction

  always_ff @(posedge clk) begin
    if (doPush) mem[wrPtr] <= pushData;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      wrPtr <= '0;
      rdPtr <= '0;
      count <= '0;
    end else begin
      if (doPush) wrPtr <= nextPtr(wrPtr);
      if (doPop)  rdPtr <= nextPtr(rdPtr);
      if (doPush && !doPop)      count <= count + 1'b1;
      else if (doPop && !doPush) count <= count - 1'b1;
    end
  end

  a_r3_no_overflow: assert property (@(posedge clk) disable iff (!rstN)
    count <= CNT_W'(DEPTH));
  a_r3_full_drop: assert property (@(posedge clk) disable iff (!rstN)
    (push && full && !pop) |=> $stable(count));
  a_r5_empty_hold: assert property (@(posedge clk) disable iff (!rstN)
    (pop && empty && !push) |=> $stable(count) && $stable(rdPtr));
  a_r2_push_count: assert property (@(posedge clk) disable iff (!rstN)
    (push && !full && !pop) |=> count == $past(count) + 1'b1);
endmodule

// File: rtl/spi_wm_dpath.sv
module spi_wm_dpath
  import spi_wm_pkg::*;
#(
  parameter int DEPTH = 8,
  localparam int CNT_W = $clog2(DEPTH + 1)
) (
  input  logic              clk,
  input  logic              rstN,
  input  fifoStrobe_t       strobe,
  input  logic              txPopReq,
  output logic [WORD_W-1:0] txPopData,
  output logic              txHasData,
  input  logic              rxPushReq,
  input  logic [WORD_W-1:0] rxPushData,
  output logic              rxHasRoom,
  output logic [CNT_W-1:0]  txCount,
  output logic [CNT_W-1:0]  rxCount,
  output logic              txFull,
  output logic              rxEmpty,
  output logic [WORD_W-1:0] rxHead
);
  logic txEmpty, rxFull;

  spi_wm_fifo #(.DEPTH(DEPTH), .WIDTH(WORD_W)) txFifo_i (
    .clk(clk), .rstN(rstN),
    .push(strobe.txPush), .pushData(strobe.txWord),
    .pop(txPopReq), .popData(txPopData),
    .count(txCount), .full(txFull), .empty(txEmpty));

  spi_wm_fifo #(.DEPTH(DEPTH), .WIDTH(WORD_W)) rxFifo_i (
    .clk(clk), .rstN(rstN),
    .push(rxPushReq), .pushData(rxPushData),
    .pop(strobe.rxPop), .popData(rxHead),
    .count(rxCount), .full(rxFull), .empty(rxEmpty));

  assign txHasData = !txEmpty;
  assign rxHasRoom = !rxFull;
endmodule

// File: rtl/spi_wm_ctrl.sv
module spi_wm_ctrl
  import spi_wm_pkg::*;
#(
  parameter int DEPTH  = 8,
  parameter int NUM_CS = 4,
  parameter int ADDR_W = 8,
  localparam int CNT_W = $clog2(DEPTH + 1),
  localparam int CS_W  = (NUM_CS > 1) ? $clog2(NUM_CS) : 1
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              busSel,
  input  logic              busWrite,
  input  logic [ADDR_W-1:0] busAddr,
  input  logic [31:0]       busWdata,
  output logic [31:0]       busRdata,
  output logic              irq,
  output fifoStrobe_t       strobe,
  input  logic [CNT_W-1:0]  txCount,
  input  logic [CNT_W-1:0]  rxCount,
  input  logic              txFull,
  input  logic              rxEmpty,
  input  logic [WORD_W-1:0] rxHead,
  output logic [11:0]       sckDiv,
  output logic [1:0]        sckMode,
  output logic [CS_W-1:0]   csId,
  output logic [NUM_CS-1:0] csDefault,
  output logic [1:0]        csMode,
  output logic [31:0]       delay0,
  output logic [31:0]       delay1,
  output logic [31:0]       frameFmt,
  output logic              flashCtrl,
  output logic [31:0]       flashFmt
);
  logic [CNT_W-1:0] txMark, rxMark;
  logic [1:0] ieReg, ipBits;
  logic wrEn, rdEn;
  logic [7:0] offset;

  assign wrEn   = busSel && busWrite;
  assign rdEn   = busSel && !busWrite;
  assign offset = 8'(busAddr);

  assign ipBits[0] = (txCount < txMark);
  assign ipBits[1] = (rxCount > rxMark);
  assign irq       = |(ieReg & ipBits);

  always_comb begin
    strobe.txPush = wrEn && (offset == OFF_TXDATA);
    strobe.txWord = busWdata[WORD_W-1:0];
    strobe.rxPop  = rdEn && (offset == OFF_RXDATA) && !rxEmpty;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      sckDiv    <= 12'd3;
      sckMode   <= '0;
      csId      <= '0;
      csDefault <= '1;
      csMode    <= '0;
      delay0    <= 32'h0001_0001;
      delay1    <= 32'h0000_0001;
      frameFmt  <= 32'h0008_0000;
      flashCtrl <= 1'b0;
      flashFmt  <= '0;
      txMark    <= CNT_W'(1);
      rxMark    <= '0;
      ieReg     <= '0;
    end else if (wrEn) begin
      case (offset)
        OFF_SCKDIV:  sckDiv    <= busWdata[11:0];
        OFF_SCKMODE: sckMode   <= busWdata[1:0];
        OFF_CSID:    csId      <= busWdata[CS_W-1:0];
        OFF_CSDEF:   csDefault <= busWdata[NUM_CS-1:0];
        OFF_CSMODE:  csMode    <= busWdata[1:0];
        OFF_DLY0:    delay0    <= busWdata & DLY_MASK;
        OFF_DLY1:    delay1    <= busWdata & DLY_MASK;
        OFF_FMT:     frameFmt  <= busWdata & FMT_MASK;
        OFF_FCTRL:   flashCtrl <= busWdata[0];
        OFF_FFMT:    flashFmt  <= busWdata;
        OFF_TXMARK:  txMark    <= busWdata[CNT_W-1:0];
        OFF_RXMARK:  rxMark    <= busWdata[CNT_W-1:0];
        OFF_IE:      ieReg     <= busWdata[1:0];
        default: ;
      endcase
    end
  end

  always_comb begin
    busRdata = '0;
    if (rdEn) begin
      case (offset)
        OFF_SCKDIV:  busRdata = 32'(sckDiv);
        OFF_SCKMODE: busRdata = 32'(sckMode);
        OFF_CSID:    busRdata = 32'(csId);
        OFF_CSDEF:   busRdata = 32'(csDefault);
        OFF_CSMODE:  busRdata = 32'(csMode);
        OFF_DLY0:    busRdata = delay0;
        OFF_DLY1:    busRdata = delay1;
        OFF_FMT:     busRdata = frameFmt;
        OFF_TXDATA:  busRdata = {txFull, 31'b0};
        OFF_RXDATA:  busRdata = rxEmpty ? 32'h8000_0000 : 32'(rxHead);
        OFF_TXMARK:  busRdata = 32'(txMark);
        OFF_RXMARK:  busRdata = 32'(rxMark);
        OFF_FCTRL:   busRdata = 32'(flashCtrl);
        OFF_FFMT:    busRdata = flashFmt;
        OFF_IE:      busRdata = 32'(ieReg);
        OFF_IP:      busRdata = 32'(ipBits);
        default:     busRdata = '0;
      endcase
    end
  end

  // R8: with nothing enabled the line stays low
  a_r8_quiet_when_disabled: assert property (@(posedge clk) disable iff (!rstN)
    (ieReg == 2'b00) |-> !irq);
  // R6: a drained transmit queue pends for any non-zero mark
  a_r6_drained_pends: assert property (@(posedge clk) disable iff (!rstN)
    (txCount == '0 && txMark != '0) |-> ipBits[0]);
  // R5: an empty receive queue never produces a pop strobe
  a_r5_no_pop_empty: assert property (@(posedge clk) disable iff (!rstN)
    rxEmpty |-> !strobe.rxPop);
endmodule

// File: rtl/spi_wm_regs.sv
module spi_wm_regs
  import spi_wm_pkg::*;
#(
  parameter int DEPTH  = 8,
  parameter int NUM_CS = 4,
  parameter int ADDR_W = 8,
  localparam int CNT_W = $clog2(DEPTH + 1),
  localparam int CS_W  = (NUM_CS > 1) ? $clog2(NUM_CS) : 1
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              busSel,
  input  logic              busWrite,
  input  logic [ADDR_W-1:0] busAddr,
  input  logic [31:0]       busWdata,
  output logic [31:0]       busRdata,
  output logic              irq,
  input  logic              txPopReq,
  output logic [7:0]        txPopData,
  output logic              txHasData,
  input  logic              rxPushReq,
  input  logic [7:0]        rxPushData,
  output logic              rxHasRoom,
  output logic [11:0]       sckDiv,
  output logic [1:0]        sckMode,
  output logic [CS_W-1:0]   csId,
  output logic [NUM_CS-1:0] csDefault,
  output logic [1:0]        csMode,
  output logic [31:0]       delay0,
  output logic [31:0]       delay1,
  output logic [31:0]       frameFmt,
  output logic              flashCtrl,
  output logic [31:0]       flashFmt
);
  fifoStrobe_t strobe;
  logic [CNT_W-1:0] txCount, rxCount;
  logic txFull, rxEmpty;
  logic [WORD_W-1:0] rxHead;

  spi_wm_ctrl #(.DEPTH(DEPTH), .NUM_CS(NUM_CS), .ADDR_W(ADDR_W)) ctrl_i (
    .clk(clk), .rstN(rstN),
    .busSel(busSel), .busWrite(busWrite), .busAddr(busAddr),
    .busWdata(busWdata), .busRdata(busRdata), .irq(irq),
    .strobe(strobe), .txCount(txCount), .rxCount(rxCount),
    .txFull(txFull), .rxEmpty(rxEmpty), .rxHead(rxHead),
    .sckDiv(sckDiv), .sckMode(sckMode), .csId(csId), .csDefault(csDefault),
    .csMode(csMode), .delay0(delay0), .delay1(delay1), .frameFmt(frameFmt),
    .flashCtrl(flashCtrl), .flashFmt(flashFmt));

  spi_wm_dpath #(.DEPTH(DEPTH)) dpath_i (
    .clk(clk), .rstN(rstN), .strobe(strobe),
    .txPopReq(txPopReq), .txPopData(txPopData), .txHasData(txHasData),
    .rxPushReq(rxPushReq), .rxPushData(rxPushData), .rxHasRoom(rxHasRoom),
    .txCount(txCount), .rxCount(rxCount), .txFull(txFull),
    .rxEmpty(rxEmpty), .rxHead(rxHead));
endmodule

// File: tb/spi_wm_regs_tb_top.sv
module spi_wm_regs_tb_top;
  localparam int CLK_PERIOD = 10;
  localparam int DEPTH  = 8;
  localparam int NUM_CS = 4;

  logic clk = 0, rstN = 0;
  logic busSel = 0, busWrite = 0;
  logic [7:0] busAddr = '0;
  logic [31:0] busWdata = '0, busRdata;
  logic irq;
  logic txPopReq = 0, txHasData, rxPushReq = 0, rxHasRoom;
  logic [7:0] txPopData, rxPushData = '0;
  logic [11:0] sckDiv;
  logic [1:0] sckMode, csMode;
  logic [1:0] csId;
  logic [NUM_CS-1:0] csDefault;
  logic [31:0] delay0, delay1, frameFmt, flashFmt;
  logic flashCtrl;

  int checks = 0, fails = 0;
  bit finished = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  spi_wm_regs #(.DEPTH(DEPTH), .NUM_CS(NUM_CS), .ADDR_W(8)) dut_i (
    .clk(clk), .rstN(rstN), .busSel(busSel), .busWrite(busWrite),
    .busAddr(busAddr), .busWdata(busWdata), .busRdata(busRdata), .irq(irq),
    .txPopReq(txPopReq), .txPopData(txPopData), .txHasData(txHasData),
    .rxPushReq(rxPushReq), .rxPushData(rxPushData), .rxHasRoom(rxHasRoom),
    .sckDiv(sckDiv), .sckMode(sckMode), .csId(csId), .csDefault(csDefault),
    .csMode(csMode), .delay0(delay0), .delay1(delay1), .frameFmt(frameFmt),
    .flashCtrl(flashCtrl), .flashFmt(flashFmt));

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual 0x%08h expected 0x%08h", req, act, exp);
    end
  endtask

  task automatic busWr(input logic [7:0] a, input logic [31:0] d);
    @(negedge clk);
    busSel = 1; busWrite = 1; busAddr = a; busWdata = d;
    @(posedge clk); #1;
    busSel = 0; busWrite = 0;
  endtask

  task automatic busRd(input logic [7:0] a, output logic [31:0] d);
    @(negedge clk);
    busSel = 1; busWrite = 0; busAddr = a;
    #1 d = busRdata;
    @(posedge clk); #1;
    busSel = 0;
  endtask

  task automatic rdChk(input string req, input logic [7:0] a, input logic [31:0] exp);
    logic [31:0] d;
    busRd(a, d);
    chk(req, d, exp);
  endtask

  task automatic txPopOne(output logic [7:0] w);
    @(negedge clk);
    w = txPopData; txPopReq = 1;
    @(posedge clk); #1;
    txPopReq = 0;
  endtask

  task automatic rxPushOne(input logic [7:0] w);
    @(negedge clk);
    rxPushReq = 1; rxPushData = w;
    @(posedge clk); #1;
    rxPushReq = 0;
  endtask

  task automatic sampleChk(input string req, input logic [31:0] act, input logic [31:0] exp);
    @(negedge clk); #1;
    chk(req, act, exp);
  endtask

  task automatic t_reset;
    rdChk("R1 ie",     8'h70, 32'h0);
    rdChk("R1 txmark", 8'h50, 32'h1);
    rdChk("R1 rxmark", 8'h54, 32'h0);
    rdChk("R1 fctrl",  8'h60, 32'h0);
    rdChk("R1 ip",     8'h74, 32'h1);
    sampleChk("R1 irq", 32'(irq), 32'h0);
  endtask

  task automatic t_tx_order;
    logic [7:0] w;
    busWr(8'h48, 32'h0000_01A5);
    busWr(8'h48, 32'h0000_003C);
    sampleChk("R2 hasdata", 32'(txHasData), 32'h1);
    rdChk("R6 ip tx busy", 8'h74, 32'h0);
    txPopOne(w); chk("R2 first word", 32'(w), 32'hA5);
    txPopOne(w); chk("R2 second word", 32'(w), 32'h3C);
    sampleChk("R2 drained", 32'(txHasData), 32'h0);
    rdChk("R6 ip tx drained", 8'h74, 32'h1);
  endtask

  task automatic t_tx_mark;
    logic [7:0] w;
    busWr(8'h50, 32'd3);
    busWr(8'h48, 32'h11);
    busWr(8'h48, 32'h22);
    rdChk("R6 count 2 below mark 3", 8'h74, 32'h1);
    busWr(8'h48, 32'h33);
    rdChk("R6 count 3 at mark 3", 8'h74, 32'h0);
    for (int i = 0; i < 3; i++) txPopOne(w);
    busWr(8'h50, 32'd1);
  endtask

  task automatic t_tx_full;
    logic [7:0] w;
    for (int i = 0; i < DEPTH - 1; i++) busWr(8'h48, 32'(8'h40 + i));
    rdChk("R3 not full at DEPTH-1", 8'h48, 32'h0);
    busWr(8'h48, 32'(8'h40 + DEPTH - 1));
    rdChk("R3 full flag", 8'h48, 32'h8000_0000);
    busWr(8'h48, 32'hEE);
    for (int i = 0; i < DEPTH; i++) begin
      txPopOne(w);
      chk("R3 drain order", 32'(w), 32'(8'h40 + i));
    end
    sampleChk("R3 extra write dropped", 32'(txHasData), 32'h0);
  endtask

  task automatic t_rx;
    busWr(8'h54, 32'd2);
    rxPushOne(8'h81);
    rxPushOne(8'h82);
    rdChk("R7 two held, mark 2", 8'h74, 32'h1);
    rxPushOne(8'h83);
    rdChk("R7 three held, mark 2", 8'h74, 32'h3);
    rdChk("R4 pop 1", 8'h4C, 32'h81);
    rdChk("R4 pop 2", 8'h4C, 32'h82);
    rdChk("R4 pop 3", 8'h4C, 32'h83);
    rdChk("R5 empty read", 8'h4C, 32'h8000_0000);
    rdChk("R5 empty read again", 8'h4C, 32'h8000_0000);
    rxPushOne(8'h5A);
    rdChk("R5 next after empty", 8'h4C, 32'h5A);
    for (int i = 0; i < DEPTH; i++) rxPushOne(8'(i));
    sampleChk("R4 no room", 32'(rxHasRoom), 32'h0);
    for (int i = 0; i < DEPTH; i++) rdChk("R4 full drain", 8'h4C, 32'(i));
    sampleChk("R4 room again", 32'(rxHasRoom), 32'h1);
    busWr(8'h54, 32'd0);
  endtask

  task automatic t_irq;
    busWr(8'h70, 32'h2);
    sampleChk("R8 rx enabled, none pending", 32'(irq), 32'h0);
    rxPushOne(8'h99);
    sampleChk("R8 rx pending", 32'(irq), 32'h1);
    busWr(8'h74, 32'h0);
    rdChk("R8 ip write ignored", 8'h74, 32'h3);
    rdChk("R8 clear by pop", 8'h4C, 32'h99);
    sampleChk("R8 rx drained", 32'(irq), 32'h0);
    busWr(8'h70, 32'h1);
    sampleChk("R8 tx drained enabled", 32'(irq), 32'h1);
    busWr(8'h70, 32'h0);
    sampleChk("R8 disabled", 32'(irq), 32'h0);
  endtask

  task automatic t_cs_probe;
    busWr(8'h14, 32'h0);
    rdChk("R9 cleared", 8'h14, 32'h0);
    busWr(8'h14, 32'hFFFF_FFFF);
    rdChk("R9 probe", 8'h14, 32'h0000_000F);
    sampleChk("R9 port", 32'(csDefault), 32'hF);
  endtask

  task automatic t_unmapped;
    busWr(8'h00, 32'h0000_0123);
    busWr(8'h20, 32'hDEAD_BEEF);
    busWr(8'h08, 32'hFFFF_FFFF);
    rdChk("R10 read 0x20", 8'h20, 32'h0);
    rdChk("R10 read 0x08", 8'h08, 32'h0);
    rdChk("R10 neighbour intact", 8'h00, 32'h123);
    rdChk("R10 ie intact", 8'h70, 32'h0);
  endtask

  task automatic t_cfg;
    busWr(8'h00, 32'hFFFF_FFFF);
    rdChk("R11 sckdiv", 8'h00, 32'h0000_0FFF);
    busWr(8'h04, 32'hFFFF_FFFF);
    rdChk("R11 sckmode", 8'h04, 32'h3);
    busWr(8'h18, 32'hFFFF_FFFE);
    rdChk("R11 csmode", 8'h18, 32'h2);
    busWr(8'h40, 32'hFFFF_FFFF);
    rdChk("R11 fmt", 8'h40, 32'h000F_000F);
    sampleChk("R11 ports", {sckDiv, 18'b0, sckMode}, {12'hFFF, 18'b0, 2'b11});
    sampleChk("R11 fmt port", frameFmt, 32'h000F_000F);
  endtask

  initial begin
    repeat (3) @(posedge clk);
    #1 rstN = 1;
    t_reset();
    t_tx_order();
    t_tx_mark();
    t_tx_full();
    t_rx();
    t_irq();
    t_cs_probe();
    t_unmapped();
    t_cfg();
    finished = 1;
    $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
    $finish;
  end

  initial begin
    #(CLK_PERIOD * 50000);
    if (!finished) begin
      checks++;
      fails++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
      $finish;
    end
  end
endmodule